// File: doc/BRIEF.md
# Slotted Random-Access Channel Arbiter

This block decides when a half-duplex packet radio transmitter may key up and take the shared channel. A divider derived from the clock frequency produces a periodic evaluation tick, nominally every 10 ms. On each tick the arbiter looks at the transmitter and the channel. If the transmitter is idle and a frame is waiting, it either starts at once (full duplex) or runs a slotted p-persistent access scheme (half duplex).

In half-duplex operation, a busy channel keeps reloading a slot countdown, so a random draw can only happen after a whole slot of clear air. When the countdown runs out, the counter is reloaded and an internal 16-bit LFSR supplies a random byte. Access is granted when that byte does not exceed the persistence setting; otherwise the attempt waits for the next slot. A grant is a single-clock start pulse. A frame sender that manages the transmitter consumes this pulse.

Top module: `chan_access_arb`

## Requirements
- R1: After reset, `start_tx` and `tick_o` are low.
- R2: `tick_o` is high for exactly one clock once every CLK_HZ/TICK_HZ clocks.
- R3: No start pulse is produced unless both `tx_idle` and `frame_pending` are high at the tick.
- R4: When `duplex_mode` is nonzero, every tick with `tx_idle` and `frame_pending` high produces a start pulse, whatever the values of `carrier` and `persist`.
- R5: In half duplex, a tick with `carrier` high produces no start and reloads the slot counter. With `persist`=255, the first start after carrier drops comes on the Nth clear tick, where N = slot_ms/10 (integer division, minimum 1).
- R6: In half duplex on a clear channel with `persist`=255, starts repeat every N ticks. A slot time below 10 ms gives a start on every tick.
- R7: On slot expiry the low byte of a 16-bit Galois LFSR (right shift, toggle mask 0xB400, nonzero seed at reset, advancing every clock) is drawn. A start happens only if the byte is not greater than `persist`. Over 256 expiries, `persist`=0 grants at most 8 times and `persist`=128 grants between 80 and 176 times.
- R8: `start_tx` is high for exactly one clock, and only in the clock that follows a `tick_o` pulse.
- R9: A one-clock `slot_wr` pulse reloads the slot counter from `slot_ms` at once, so the countdown restarts with the new slot length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier | input | 1 | Channel busy (carrier detected) |
| tx_idle | input | 1 | Transmitter is not sending |
| frame_pending | input | 1 | At least one frame waits to be sent |
| duplex_mode | input | 2 | 0 = half duplex, any other value = full duplex |
| slot_ms | input | SLOT_W | Slot time in milliseconds |
| slot_wr | input | 1 | Pulse: new slot time, reload counter |
| persist | input | 8 | Persistence threshold 0..255 |
| tick_o | output | 1 | Evaluation tick pulse |
| start_tx | output | 1 | One-clock grant to start transmitting |

## Verification
The bench drops carrier partway through a countdown and expects the full slot to be counted again. A design that only paused the counter would grant early. It shortens the slot through `slot_wr` mid-countdown; an arbiter that ignored the write would grant late. It checks that slot times under 10 ms expire on every tick rather than wrapping the counter, which would stall access for thousands of ticks. Full duplex is driven with carrier high and `persist` at 0 to catch a design that still consults either. Grant rates at persistence 0 and 128 expose an inverted or off-by-one comparison.

// File: rtl/chan_access_arb.sv
module chan_access_arb #(
  parameter int          CLK_HZ   = 50_000_000,
  parameter int          TICK_HZ  = 100,
  parameter int          TICK_MS  = 10,
  parameter int          SLOT_W   = 16,
  parameter int          DEF_SLOT = 100,
  parameter logic [15:0] SEED     = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier,
  input  logic              tx_idle,
  input  logic              frame_pending,
  input  logic [1:0]        duplex_mode,
  input  logic [SLOT_W-1:0] slot_ms,
  input  logic              slot_wr,
  input  logic [7:0]        persist,
  output logic              tick_o,
  output logic              start_tx
);
  localparam int TICK_CYCLES = (CLK_HZ / TICK_HZ) < 2 ? 2 : CLK_HZ / TICK_HZ;
  localparam int DIV_W = $clog2(TICK_CYCLES);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_CYCLES - 1);
  localparam logic [SLOT_W-1:0] DEF_RELOAD = SLOT_W'(DEF_SLOT / TICK_MS);

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_cnt;
  logic [15:0]       lfsr;
  logic [SLOT_W-1:0] reload;
  logic              ready, full_dup, expire, grant;

  assign reload   = slot_ms / SLOT_W'(TICK_MS);
  assign ready    = tx_idle && frame_pending;
  assign full_dup = duplex_mode != 2'd0;
  assign expire   = slot_cnt <= SLOT_W'(1);
  assign grant    = tick_o && ready &&
                    (full_dup || (!carrier && expire && lfsr[7:0] <= persist));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      div_q  <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      tick_o <= div_q == DIV_LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= DEF_RELOAD;
    end else if (slot_wr) begin
      slot_cnt <= reload;
    end else if (tick_o && ready && !full_dup) begin
      if (carrier || expire) slot_cnt <= reload;
      else                   slot_cnt <= slot_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_tx <= 1'b0;
    else        start_tx <= grant;
  end
endmodule

// File: rtl/chan_access_arb_chk.sv
module chan_access_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       carrier,
  input logic       tx_idle,
  input logic       frame_pending,
  input logic [1:0] duplex_mode,
  input logic       tick_o,
  input logic       start_tx
);
  p_tick_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_tx |-> $past(tx_idle && frame_pending));
  p_full_duplex_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && tx_idle && frame_pending && duplex_mode != 2'd0) |=> start_tx);
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && carrier && duplex_mode == 2'd0) |=> !start_tx);
  p_one_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_tx |=> !start_tx);
  p_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_tx |-> $past(tick_o));
endmodule

bind chan_access_arb chan_access_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .carrier(carrier), .tx_idle(tx_idle),
  .frame_pending(frame_pending), .duplex_mode(duplex_mode),
  .tick_o(tick_o), .start_tx(start_tx)
);

// File: tb/tb_chan_access_arb.sv
module tb_chan_access_arb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_CYC   = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        carrier = 1'b0, tx_idle = 1'b0, frame_pending = 1'b0;
  logic [1:0]  duplex_mode = 2'd0;
  logic [15:0] slot_ms = 16'd100;
  logic        slot_wr = 1'b0;
  logic [7:0]  persist = 8'd64;
  logic        tick_o, start_tx;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_access_arb #(.CLK_HZ(1000), .TICK_HZ(100)) dut (
    .clk(clk), .rst_n(rst_n), .carrier(carrier), .tx_idle(tx_idle),
    .frame_pending(frame_pending), .duplex_mode(duplex_mode),
    .slot_ms(slot_ms), .slot_wr(slot_wr), .persist(persist),
    .tick_o(tick_o), .start_tx(start_tx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick(output bit got);
    do @(negedge clk); while (!tick_o);
    @(negedge clk);
    got = start_tx;
  endtask

  task automatic run_ticks(input int n, output int cnt);
    bit g;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      do_tick(g);
      cnt += g;
    end
  endtask

  task automatic load_slot(input int ms);
    bit g;
    do_tick(g);
    slot_ms = 16'(ms);
    slot_wr = 1'b1;
    @(negedge clk);
    slot_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk(start_tx == 1'b0 && tick_o == 1'b0, "R1", {start_tx, tick_o}, 0);
  endtask

  task automatic t_tick;
    int gap = 0;
    do @(negedge clk); while (!tick_o);
    @(negedge clk);
    chk(tick_o == 1'b0, "R2 width", tick_o, 0);
    gap = 1;
    while (!tick_o) begin
      @(negedge clk);
      gap++;
    end
    chk(gap == TICK_CYC, "R2 period", gap, TICK_CYC);
  endtask

  task automatic t_gate;
    int c;
    duplex_mode = 2'd0; carrier = 1'b0; persist = 8'd255;
    load_slot(5);
    tx_idle = 1'b0; frame_pending = 1'b1;
    run_ticks(6, c);
    chk(c == 0, "R3 busy transmitter", c, 0);
    tx_idle = 1'b1; frame_pending = 1'b0;
    run_ticks(6, c);
    chk(c == 0, "R3 nothing queued", c, 0);
    frame_pending = 1'b1;
    run_ticks(6, c);
    chk(c == 6, "R6 short slot every tick", c, 6);
  endtask

  task automatic t_duplex;
    int c;
    carrier = 1'b1; persist = 8'd0; tx_idle = 1'b1; frame_pending = 1'b1;
    load_slot(100);
    duplex_mode = 2'd1;
    run_ticks(5, c);
    chk(c == 5, "R4 mode 1", c, 5);
    duplex_mode = 2'd3;
    run_ticks(5, c);
    chk(c == 5, "R4 mode 3", c, 5);
    duplex_mode = 2'd0;
    carrier = 1'b0;
  endtask

  task automatic t_slot;
    bit g;
    persist = 8'd255;
    load_slot(50);
    for (int i = 1; i <= 10; i++) begin
      do_tick(g);
      chk(g == (i % 5 == 0), "R6 slot period", g, (i % 5 == 0));
    end
  endtask

  task automatic t_carrier;
    bit g;
    int c;
    persist = 8'd255;
    load_slot(50);
    run_ticks(3, c);
    chk(c == 0, "R5 before carrier", c, 0);
    carrier = 1'b1;
    run_ticks(2, c);
    chk(c == 0, "R5 carrier blocks", c, 0);
    carrier = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      do_tick(g);
      chk(g == (i == 5), "R5 full slot after carrier", g, (i == 5));
    end
  endtask

  task automatic t_rewrite;
    bit g;
    int c;
    persist = 8'd255;
    load_slot(50);
    run_ticks(3, c);
    load_slot(30);
    for (int i = 1; i <= 3; i++) begin
      do_tick(g);
      chk(g == (i == 3), "R9 reload on write", g, (i == 3));
    end
  endtask

  task automatic t_persist;
    int c;
    load_slot(5);
    persist = 8'd0;
    run_ticks(256, c);
    chk(c <= 8, "R7 persist 0", c, 8);
    persist = 8'd128;
    run_ticks(256, c);
    chk(c >= 80 && c <= 176, "R7 persist 128", c, 128);
  endtask

  task automatic t_pulse_width;
    int hi = 0;
    persist = 8'd255;
    load_slot(5);
    for (int i = 0; i < 3 * TICK_CYC; i++) begin
      @(negedge clk);
      hi += start_tx;
      if (start_tx) begin
        @(negedge clk);
        chk(start_tx == 1'b0, "R8 single clock", start_tx, 0);
      end
    end
    chk(hi >= 2, "R8 pulses seen", hi, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_tick();
    t_gate();
    t_duplex();
    t_slot();
    t_carrier();
    t_rewrite();
    t_persist();
    t_pulse_width();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule